// File: doc/BRIEF.md
# Dual Match Timer

This block holds two independent event timers. Each one is a 32-bit up-counter that advances once every N+1 clocks, where N is a divide value from software. Each counter has a match register. Software stops a channel, loads the counter (usually with zero), writes the required delay into the match register, and then sets the enable bits. When the counter steps onto the match value, a sticky status bit for that channel is set. Each channel drives its own interrupt line, which follows the status bit while the channel's interrupt enable is set.

The registers sit on a simple 32-bit bus with a single-cycle write strobe and a combinational read. The two channels use the same layout, placed 4 bytes apart. One status register collects one bit per channel. Writing 1 to a status bit clears it. If a new match and a software clear hit the same bit in the same cycle, the match wins, so no event is lost. A synchronous reset returns every register to zero.

Top module: `dual_match_timer`

## Requirements
- R1: While and after a synchronous reset (`rst` high), every control, match, counter and status register reads 0 and both `irq` bits are 0.
- R2: Channel k has a control register at 0x00+4k, a match register at 0x18+4k and a counter register at 0x48+4k; the status register is at 0x60. Control reads back the divide value in bits [31:16] and the enables in bits [2:0], with all other bits 0. Match and counter registers read back what was written. An unmapped address reads 0.
- R3: Control bit 0 (count enable) makes the counter advance by one every N+1 clocks, where N is control bits [31:16]. The first step comes N+1 clocks after the enabling write. With bit 0 clear, the counter holds its value.
- R4: Control bit 1 (match enable) makes the channel set status bit k on the clock edge where its counter steps onto the match value. With counter 0, match 2 and N=0, the bit is set two clocks after the enabling write.
- R5: `irq[k]` is 1 exactly when status bit k is set and control bit 2 (interrupt enable) of channel k is set.
- R6: A write to the status register clears every bit k whose write-data bit k is 1 and leaves bits written with 0 unchanged. Writing 0xFFFF clears all bits.
- R7: After a match the counter keeps counting and wraps from 0xFFFFFFFF to 0. The status bit stays set until it is cleared. A later match sets it again.
- R8: When a match and a status clear of the same bit fall in the same cycle, the bit ends up set.
- R9: A counter write loads the value at once and restarts the divide phase, so the next step comes N+1 clocks later. Activity on one channel never changes the other channel's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 2 | Interrupt line per channel |

## Verification
The embedded properties check on every cycle the following cycle-local rules:
- the divider phase never passes its limit;
- a stopped counter stays still;
- a counter write lands;
- the all-ones value wraps to zero;
- a match leaves the counter on the match value;
- a set beats a clear on the status bits;
- a clear empties a bit;
- a set bit stays sticky.

Only the directed scenarios can show the end-to-end behaviour:
- the exact clock count from an enable or a counter write to the first step and to the match;
- the register layout and readback masking;
- the interrupt mask seen at the pins;
- a re-armed match after a clear;
- the two channels staying independent.

// File: rtl/mtm_pkg.sv
package mtm_pkg;

   // Default register layout (byte offsets)
   localparam int CTRL_OFS_D   = 'h00;
   localparam int MATCH_OFS_D  = 'h18;
   localparam int COUNT_OFS_D  = 'h48;
   localparam int STATUS_OFS_D = 'h60;
   localparam int STRIDE_D     = 4;

   // Lowest bit of the divide field in a control word
   localparam int DIV_LSB = 16;
   localparam int EN_W    = 3;

   // Enable field, bits [2:0] of a control word
   typedef struct packed {
      logic irq;    // bit 2
      logic match;  // bit 1
      logic count;  // bit 0
   } ch_en_t;

endpackage

// File: rtl/mtm_decode.sv
module mtm_decode #(
   parameter int ADDR_W     = 8,
   parameter int NUM_CH     = 2,
   parameter int STRIDE     = 4,
   parameter int CTRL_OFS   = 'h00,
   parameter int MATCH_OFS  = 'h18,
   parameter int COUNT_OFS  = 'h48,
   parameter int STATUS_OFS = 'h60
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_CH-1:0] ctrl_sel,
   output logic [NUM_CH-1:0] match_sel,
   output logic [NUM_CH-1:0] cnt_sel,
   output logic              stat_sel
);

   always_comb begin
      for (int k = 0; k < NUM_CH; k++) begin
         ctrl_sel[k]  = (addr == ADDR_W'(CTRL_OFS  + k * STRIDE));
         match_sel[k] = (addr == ADDR_W'(MATCH_OFS + k * STRIDE));
         cnt_sel[k]   = (addr == ADDR_W'(COUNT_OFS + k * STRIDE));
      end
      stat_sel = (addr == ADDR_W'(STATUS_OFS));
   end

   // at most one register answers any address
   always_comb begin
      assert ($countones({ctrl_sel, match_sel, cnt_sel, stat_sel}) <= 1)
         else $error("p_unique_decode_r2: overlapping register windows");
   end

endmodule

// File: rtl/mtm_channel.sv
module mtm_channel
   import mtm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctrl_we,
   input  logic              match_we,
   input  logic              cnt_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DIV_W-1:0]  div_o,
   output ch_en_t            en_o,
   output logic [DATA_W-1:0] match_o,
   output logic [DATA_W-1:0] cnt_o,
   output logic              hit_o
);

   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-1:0]  presc_q;
   ch_en_t            en_q;
   logic [DATA_W-1:0] match_q;
   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] cnt_inc;
   logic              tick;
   logic              hit;

   // one count step when the divider phase reaches its limit; any
   // write to this channel's control or counter takes precedence
   assign tick    = en_q.count && (presc_q == div_q) && !ctrl_we && !cnt_we;
   assign cnt_inc = cnt_q + DATA_W'(1);
   assign hit     = tick && en_q.match && (cnt_inc == match_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q   <= '0;
         en_q    <= '0;
         presc_q <= '0;
         match_q <= '0;
         cnt_q   <= '0;
      end else begin
         if (ctrl_we) begin
            div_q <= wdata[DIV_LSB +: DIV_W];
            en_q  <= ch_en_t'(wdata[EN_W-1:0]);
         end
         if (match_we)
            match_q <= wdata;
         if (cnt_we)
            cnt_q <= wdata;
         else if (tick)
            cnt_q <= cnt_inc;
         if (ctrl_we || cnt_we || !en_q.count || (presc_q == div_q))
            presc_q <= '0;
         else
            presc_q <= presc_q + DIV_W'(1);
      end
   end

   assign div_o   = div_q;
   assign en_o    = en_q;
   assign match_o = match_q;
   assign cnt_o   = cnt_q;
   assign hit_o   = hit;

   p_presc_bound_r3: assert property (@(posedge clk) disable iff (rst)
      presc_q <= div_q);

   p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
      (!en_q.count && !cnt_we) |=> $stable(cnt_q));

   p_load_r9: assert property (@(posedge clk) disable iff (rst)
      cnt_we |=> (cnt_q == $past(wdata)));

   p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
      (tick && (cnt_q == '1)) |=> (cnt_q == '0));

   p_hit_lands_r4: assert property (@(posedge clk) disable iff (rst)
      (hit && !match_we) |=> (cnt_q == match_q));

endmodule

// File: rtl/mtm_status.sv
module mtm_status #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] set_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] st_o
);

   logic [NUM_CH-1:0] st_q;

   always_ff @(posedge clk) begin
      if (rst)
         st_q <= '0;
      else
         st_q <= (st_q & ~clr_i) | set_i;
   end

   assign st_o = st_q;

   p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      (|set_i) |=> ((st_q & $past(set_i)) == $past(set_i)));

   p_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (|(clr_i & ~set_i)) |=> ((st_q & $past(clr_i & ~set_i)) == '0));

   p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (|(st_q & ~clr_i)) |=> ((st_q & $past(st_q & ~clr_i)) == $past(st_q & ~clr_i)));

endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
   import mtm_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int NUM_CH     = 2,
   parameter int DIV_W      = 16,
   parameter int STRIDE     = STRIDE_D,
   parameter int CTRL_OFS   = CTRL_OFS_D,
   parameter int MATCH_OFS  = MATCH_OFS_D,
   parameter int COUNT_OFS  = COUNT_OFS_D,
   parameter int STATUS_OFS = STATUS_OFS_D,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq
);

   localparam int WIN_BYTES = NUM_CH * STRIDE;

   // elaboration checks
   if (DIV_LSB + DIV_W > DATA_W) begin : g_bad_div
      $error("divide field does not fit in a control word");
   end
   if (NUM_CH > DATA_W || NUM_CH < 1) begin : g_bad_ch
      $error("channel count out of range");
   end
   if (WIN_BYTES > MATCH_OFS - CTRL_OFS || WIN_BYTES > COUNT_OFS - MATCH_OFS
       || WIN_BYTES > STATUS_OFS - COUNT_OFS) begin : g_bad_map
      $error("register windows overlap");
   end
   if (STATUS_OFS >= (1 << ADDR_W)) begin : g_bad_addr
      $error("address width too small for register map");
   end

   logic [NUM_CH-1:0] ctrl_sel, match_sel, cnt_sel;
   logic              stat_sel;
   logic [NUM_CH-1:0] hit;
   logic [NUM_CH-1:0] ien;
   logic [NUM_CH-1:0] status;
   logic [NUM_CH-1:0] clr;
   logic [DIV_W-1:0]  ch_div   [NUM_CH];
   ch_en_t            ch_en    [NUM_CH];
   logic [DATA_W-1:0] ch_match [NUM_CH];
   logic [DATA_W-1:0] ch_cnt   [NUM_CH];

   mtm_decode #(
      .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .STRIDE(STRIDE),
      .CTRL_OFS(CTRL_OFS), .MATCH_OFS(MATCH_OFS),
      .COUNT_OFS(COUNT_OFS), .STATUS_OFS(STATUS_OFS)
   ) u_dec (
      .addr(bus_addr), .ctrl_sel(ctrl_sel), .match_sel(match_sel),
      .cnt_sel(cnt_sel), .stat_sel(stat_sel)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      mtm_channel #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ch (
         .clk(clk), .rst(rst),
         .ctrl_we(bus_wr && ctrl_sel[k]),
         .match_we(bus_wr && match_sel[k]),
         .cnt_we(bus_wr && cnt_sel[k]),
         .wdata(bus_wdata),
         .div_o(ch_div[k]), .en_o(ch_en[k]),
         .match_o(ch_match[k]), .cnt_o(ch_cnt[k]),
         .hit_o(hit[k])
      );
      assign ien[k] = ch_en[k].irq;
   end

   assign clr = (bus_wr && stat_sel) ? bus_wdata[NUM_CH-1:0] : '0;

   mtm_status #(.NUM_CH(NUM_CH)) u_stat (
      .clk(clk), .rst(rst), .set_i(hit), .clr_i(clr), .st_o(status)
   );

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (rst) irq <= '0;
         else     irq <= status & ien;
      end
   end else begin : g_irq_comb
      assign irq = status & ien;
   end

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         if (ctrl_sel[k]) begin
            bus_rdata[DIV_LSB +: DIV_W] = ch_div[k];
            bus_rdata[EN_W-1:0]         = ch_en[k];
         end
         if (match_sel[k]) bus_rdata = ch_match[k];
         if (cnt_sel[k])   bus_rdata = ch_cnt[k];
      end
      if (stat_sel) bus_rdata[NUM_CH-1:0] = status;
   end

endmodule

// File: tb/tb_dual_match_timer.sv
module tb_dual_match_timer;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   localparam logic [7:0] A_CTRL0 = 8'h00, A_CTRL1 = 8'h04;
   localparam logic [7:0] A_MAT0  = 8'h18, A_MAT1  = 8'h1C;
   localparam logic [7:0] A_CNT0  = 8'h48, A_CNT1  = 8'h4C;
   localparam logic [7:0] A_STAT  = 8'h60;

   logic        clk = 1'b0;
   logic        rst;
   logic [7:0]  bus_addr;
   logic        bus_wr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   dual_match_timer dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd_reg(a, v);
      check(tag, v, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      expect_reg("R1 ctrl0 after reset", A_CTRL0, 32'h0);
      expect_reg("R1 match1 after reset", A_MAT1, 32'h0);
      expect_reg("R1 cnt1 after reset", A_CNT1, 32'h0);
      expect_reg("R1 status after reset", A_STAT, 32'h0);
      check("R1 irq after reset", {30'h0, irq}, 32'h0);
   endtask

   task automatic t_regmap();
      wr_reg(A_CTRL0, 32'hABCD_FFF8);
      expect_reg("R2 ctrl0 masked readback", A_CTRL0, 32'hABCD_0000);
      wr_reg(A_CTRL1, 32'h1234_0002);
      expect_reg("R2 ctrl1 readback", A_CTRL1, 32'h1234_0002);
      wr_reg(A_MAT1, 32'hDEAD_BEEF);
      expect_reg("R2 match1 readback", A_MAT1, 32'hDEAD_BEEF);
      wr_reg(A_MAT0, 32'h1111_2222);
      expect_reg("R2 match0 readback", A_MAT0, 32'h1111_2222);
      wr_reg(A_CNT0, 32'h0000_0055);
      expect_reg("R2 cnt0 readback", A_CNT0, 32'h0000_0055);
      expect_reg("R2 unmapped reads zero", 8'h10, 32'h0);
      wr_reg(A_CTRL0, 32'h0);
      wr_reg(A_CTRL1, 32'h0);
      wr_reg(A_CNT0, 32'h0);
   endtask

   task automatic t_prescale();
      wr_reg(A_CNT0, 32'h0);
      wr_reg(A_CTRL0, 32'h0003_0001);
      idle(3);
      expect_reg("R3 no step before N+1 clocks", A_CNT0, 32'h0);
      idle(1);
      expect_reg("R3 first step at N+1", A_CNT0, 32'h1);
      idle(4);
      expect_reg("R3 second step", A_CNT0, 32'h2);
      wr_reg(A_CTRL0, 32'h0);
      idle(5);
      expect_reg("R3 counter holds when stopped", A_CNT0, 32'h2);
   endtask

   task automatic t_min_delay();
      wr_reg(A_CNT0, 32'h0);
      wr_reg(A_MAT0, 32'h2);
      wr_reg(A_CTRL0, 32'h0000_0007);
      expect_reg("R4 no status at enable", A_STAT, 32'h0);
      idle(1);
      expect_reg("R4 no status after one step", A_STAT, 32'h0);
      idle(1);
      expect_reg("R4 status after two steps", A_STAT, 32'h1);
      check("R5 irq0 with enable", {30'h0, irq}, 32'h1);
      wr_reg(A_STAT, 32'h1);
      expect_reg("R6 W1C clears bit0", A_STAT, 32'h0);
      check("R5 irq0 drops with status", {30'h0, irq}, 32'h0);
      wr_reg(A_CTRL0, 32'h0);
   endtask

   task automatic t_wrap();
      wr_reg(A_CNT1, 32'hFFFF_FFFE);
      wr_reg(A_MAT1, 32'h1);
      wr_reg(A_CTRL1, 32'h0000_0003);
      idle(1);
      expect_reg("R7 cnt1 at all ones", A_CNT1, 32'hFFFF_FFFF);
      idle(1);
      expect_reg("R7 cnt1 wraps to zero", A_CNT1, 32'h0);
      idle(1);
      expect_reg("R4 match after wrap sets bit1", A_STAT, 32'h2);
      check("R5 irq1 masked", {30'h0, irq}, 32'h0);
      wr_reg(A_CTRL1, 32'h0000_0007);
      check("R5 irq1 unmasked", {30'h0, irq}, 32'h2);
      idle(5);
      expect_reg("R7 status sticky while counting", A_STAT, 32'h2);
      wr_reg(A_STAT, 32'h2);
      expect_reg("R6 W1C clears bit1", A_STAT, 32'h0);
      wr_reg(A_CNT1, 32'h0);
      idle(1);
      expect_reg("R7 new match sets again", A_STAT, 32'h2);
      wr_reg(A_CTRL1, 32'h0);
      check("R5 irq1 masked after disable", {30'h0, irq}, 32'h0);
   endtask

   task automatic t_set_wins();
      // bit1 is still set from the previous scenario
      wr_reg(A_CNT0, 32'h0);
      wr_reg(A_MAT0, 32'h2);
      wr_reg(A_CTRL0, 32'h0000_0003);
      idle(1);
      wr_reg(A_STAT, 32'h3);   // lands on the edge where channel 0 matches
      expect_reg("R8 set wins over clear", A_STAT, 32'h1);
      wr_reg(A_CTRL0, 32'h0);
      wr_reg(A_STAT, 32'hFFFF);
      expect_reg("R6 0xFFFF clears all", A_STAT, 32'h0);
   endtask

   task automatic t_load();
      logic [31:0] other;
      rd_reg(A_CNT1, other);
      wr_reg(A_CNT0, 32'h0);
      wr_reg(A_CTRL0, 32'h0003_0001);
      idle(2);
      wr_reg(A_CNT0, 32'd10);
      expect_reg("R9 counter load immediate", A_CNT0, 32'd10);
      idle(3);
      expect_reg("R9 divide phase restarted", A_CNT0, 32'd10);
      idle(1);
      expect_reg("R9 step N+1 after load", A_CNT0, 32'd11);
      expect_reg("R9 other channel untouched", A_CNT1, other);
      expect_reg("R9 no status from count only", A_STAT, 32'h0);
      wr_reg(A_CTRL0, 32'h0);
   endtask

   initial begin
      rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      expect_reg("R1 status during reset", A_STAT, 32'h0);
      rst = 1'b0;
      t_reset();
      t_regmap();
      t_prescale();
      t_min_delay();
      t_wrap();
      t_set_wins();
      t_load();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule